// File: doc/BRIEF.md
# LIN Slave Frame Header Detector

This block sits on the receive line of a LIN slave node and recognises the start of each frame. It samples the line once per bit time, on a strobe from an external baud generator, and finds the long dominant period that opens every header. It then follows the synchronisation byte, counting its falling edges and measuring how many bit times pass between the first and the last of them. Finally it takes in the identifier character that comes after the synchronisation byte.

A method-select input decides when a header counts as detected. With the input at 0, the break alone is enough. With the input at 1, the block needs the break, the synchronisation byte and a well-framed identifier, received one after another. A sticky header flag records the detection and drives a maskable interrupt. Software clears the flag with a status access followed by a control read. Software can also drop out of the synchronisation analysis at any time.

Top module: `lin_hdr_detect`

## Requirements
- R1: A break is recognised on the bit_tick at which rx has been sampled low for 11 consecutive bit_tick samples. Ten or fewer consecutive low samples have no effect, and a low run longer than 11 samples counts as a single break.
- R2: With hdr_method = 0, hdr_flag becomes 1 on the clock edge of the 11th low sample.
- R3: sync_state becomes 1 on the clock edge that recognises a break. It returns to 0 on the clock edge of the fifth falling edge of the synchronisation field.
- R4: A sync_exit pulse while sync_state is 1 clears sync_state on the next edge and returns the block to idle. Falling edges received after that leave edge_cnt unchanged and no identifier is taken.
- R5: A falling edge is a bit_tick sample of 0 that follows a bit_tick sample of 1. After a break, edge_cnt counts falling edges from 0 up to 5. sync_span then holds the number of bit_tick strobes from the first falling edge to the fifth. For the byte 0x55 framed by a start bit and a stop bit, sync_span is 8.
- R6: The identifier starts at the first falling edge after the synchronisation field ends. The 8 data bits that follow are taken LSB first on the next 8 strobes. If the 9th strobe samples rx high, id_byte is updated, and with hdr_method = 1 hdr_flag becomes 1 on that edge.
- R7: If the identifier's stop bit is sampled low, id_byte keeps its previous value, the block returns to idle, and hdr_flag is not set.
- R8: hdr_flag clears only on a ctrl_rd pulse that comes after a stat_rd pulse, with no header detection between the two. A ctrl_rd with no stat_rd before it leaves the flag set, and so does a detection that falls between the two reads.
- R9: hdr_irq is a registered copy of the next hdr_flag value ANDed with irq_en. With irq_en = 0, hdr_irq stays 0.
- R10: A break received while hdr_flag is 1 restarts the sequence: sync_state goes to 1 and edge_cnt to 0, and hdr_flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe, once per bit time, at which rx is sampled |
| rx | input | 1 | Receive line (0 = dominant) |
| hdr_method | input | 1 | 0: detect at break; 1: detect after break, sync byte and identifier |
| irq_en | input | 1 | Header interrupt enable |
| sync_exit | input | 1 | Software pulse that abandons the synchronisation analysis |
| stat_rd | input | 1 | Status register access strobe (first step of flag clear) |
| ctrl_rd | input | 1 | Control register read strobe (second step of flag clear) |
| hdr_flag | output | 1 | Header-detected flag |
| sync_state | output | 1 | Synchronisation field under analysis |
| hdr_irq | output | 1 | Header interrupt |
| edge_cnt | output | 3 | Falling edges counted since the last break |
| sync_span | output | 8 | Bit times from the first to the fifth falling edge |
| id_byte | output | 8 | Last identifier received with a valid stop bit |

## Verification
The bound checker watches the rules that hold on every cycle. The interrupt must always equal the flag ANDed with the enable. The flag may fall only right after a control read. The synchronisation state may rise only on a low sample at a strobe, and a software exit always drops it. The edge count never goes past five. Other behaviour only shows up in the bench's serial scenarios: the exact length of run that counts as a break, the measured span, the byte order of the identifier, rejection of a bad stop bit, the two detection methods, and the ordering rules of the clear sequence.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_IDEN = 2'd2
  } hdr_st_e;
endpackage

// File: rtl/lin_line_mon.sv
// Samples the line at each bit strobe; flags the break and falling edges.
module lin_line_mon #(
  parameter int BREAK_BITS = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic rx,
  output logic brk_hit,
  output logic fall_hit
);
  localparam int CW = $clog2(BREAK_BITS + 1);
  localparam logic [CW-1:0] LOW_MAX  = CW'(BREAK_BITS);
  localparam logic [CW-1:0] LOW_LAST = CW'(BREAK_BITS - 1);

  logic [CW-1:0] low_cnt;
  logic          rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      rx_q    <= 1'b1;
    end else if (bit_tick) begin
      rx_q <= rx;
      if (rx)
        low_cnt <= '0;
      else if (low_cnt != LOW_MAX)
        low_cnt <= low_cnt + 1'b1;
    end
  end

  // the strobe that completes the run fires once; longer runs saturate
  assign brk_hit  = bit_tick && !rx && (low_cnt == LOW_LAST);
  assign fall_hit = bit_tick && rx_q && !rx;
endmodule

// File: rtl/lin_hdr_seq.sv
// Header sequencer: synch field edge count, span measurement, identifier capture.
module lin_hdr_seq
  import lin_hdr_pkg::*;
#(
  parameter int SYNC_EDGES = 5,
  parameter int SPAN_W     = 8,
  parameter int ID_W       = 8,
  parameter int EDGE_W     = $clog2(SYNC_EDGES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              rx,
  input  logic              brk_hit,
  input  logic              fall_hit,
  input  logic              sync_exit,
  output logic              sync_state,
  output logic [EDGE_W-1:0] edge_cnt,
  output logic [SPAN_W-1:0] sync_span,
  output logic [ID_W-1:0]   id_byte,
  output logic              id_ok
);
  localparam int BW = $clog2(ID_W + 1);
  localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(SYNC_EDGES - 1);
  localparam logic [BW-1:0]     STOP_IDX  = BW'(ID_W);

  hdr_st_e           st;
  logic [SPAN_W-1:0] span_cnt;
  logic [ID_W-1:0]   shreg;
  logic [BW-1:0]     bit_idx;
  logic              started;

  assign id_ok = bit_tick && (st == ST_IDEN) && started &&
                 (bit_idx == STOP_IDX) && rx && !brk_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      sync_state <= 1'b0;
      edge_cnt   <= '0;
      span_cnt   <= '0;
      sync_span  <= '0;
      id_byte    <= '0;
      shreg      <= '0;
      bit_idx    <= '0;
      started    <= 1'b0;
    end else if (brk_hit) begin
      st         <= ST_SYNC;
      sync_state <= 1'b1;
      edge_cnt   <= '0;
      span_cnt   <= '0;
      started    <= 1'b0;
    end else begin
      case (st)
        ST_SYNC: begin
          if (sync_exit) begin
            st         <= ST_IDLE;
            sync_state <= 1'b0;
          end else begin
            if (bit_tick && edge_cnt != '0)
              span_cnt <= span_cnt + 1'b1;
            if (fall_hit) begin
              edge_cnt <= edge_cnt + 1'b1;
              if (edge_cnt == '0) begin
                span_cnt <= '0;
              end else if (edge_cnt == EDGE_LAST) begin
                sync_span  <= span_cnt + 1'b1;
                sync_state <= 1'b0;
                st         <= ST_IDEN;
                started    <= 1'b0;
                bit_idx    <= '0;
              end
            end
          end
        end
        ST_IDEN: begin
          if (!started) begin
            if (fall_hit) begin
              started <= 1'b1;
              bit_idx <= '0;
            end
          end else if (bit_tick) begin
            if (bit_idx != STOP_IDX) begin
              shreg   <= {rx, shreg[ID_W-1:1]};
              bit_idx <= bit_idx + 1'b1;
            end else begin
              if (rx)
                id_byte <= shreg;
              started <= 1'b0;
              st      <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lin_hdr_flag.sv
// Sticky header flag, two-step clear, registered interrupt.
module lin_hdr_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic stat_rd,
  input  logic ctrl_rd,
  input  logic irq_en,
  output logic hdr_flag,
  output logic hdr_irq
);
  logic armed;
  logic flag_nxt;

  always_comb begin
    flag_nxt = hdr_flag;
    if (set_ev)
      flag_nxt = 1'b1;
    else if (ctrl_rd && armed)
      flag_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_flag <= 1'b0;
      hdr_irq  <= 1'b0;
      armed    <= 1'b0;
    end else begin
      hdr_flag <= flag_nxt;
      hdr_irq  <= flag_nxt && irq_en;
      if (set_ev || ctrl_rd)
        armed <= 1'b0;
      else if (stat_rd)
        armed <= 1'b1;
    end
  end
endmodule

// File: rtl/lin_hdr_detect.sv
module lin_hdr_detect #(
  parameter int BREAK_BITS = 11,
  parameter int SYNC_EDGES = 5,
  parameter int SPAN_W     = 8,
  parameter int ID_W       = 8,
  parameter int EDGE_W     = $clog2(SYNC_EDGES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              rx,
  input  logic              hdr_method,
  input  logic              irq_en,
  input  logic              sync_exit,
  input  logic              stat_rd,
  input  logic              ctrl_rd,
  output logic              hdr_flag,
  output logic              sync_state,
  output logic              hdr_irq,
  output logic [EDGE_W-1:0] edge_cnt,
  output logic [SPAN_W-1:0] sync_span,
  output logic [ID_W-1:0]   id_byte
);
  logic brk_hit, fall_hit, id_ok, set_ev;

  lin_line_mon #(.BREAK_BITS(BREAK_BITS)) u_mon (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx(rx),
    .brk_hit(brk_hit), .fall_hit(fall_hit)
  );

  lin_hdr_seq #(
    .SYNC_EDGES(SYNC_EDGES), .SPAN_W(SPAN_W), .ID_W(ID_W), .EDGE_W(EDGE_W)
  ) u_seq (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx(rx),
    .brk_hit(brk_hit), .fall_hit(fall_hit), .sync_exit(sync_exit),
    .sync_state(sync_state), .edge_cnt(edge_cnt), .sync_span(sync_span),
    .id_byte(id_byte), .id_ok(id_ok)
  );

  // method 0: break is the header; method 1: a well-framed identifier is
  assign set_ev = hdr_method ? id_ok : brk_hit;

  lin_hdr_flag u_flag (
    .clk(clk), .rst(rst), .set_ev(set_ev), .stat_rd(stat_rd),
    .ctrl_rd(ctrl_rd), .irq_en(irq_en), .hdr_flag(hdr_flag), .hdr_irq(hdr_irq)
  );
endmodule

// File: rtl/lin_hdr_chk.sv
module lin_hdr_chk #(
  parameter int SYNC_EDGES = 5,
  parameter int EDGE_W     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_tick,
  input logic              rx,
  input logic              sync_exit,
  input logic              irq_en,
  input logic              ctrl_rd,
  input logic              hdr_flag,
  input logic              sync_state,
  input logic              hdr_irq,
  input logic [EDGE_W-1:0] edge_cnt
);
  p_irq_follows_r9: assert property (@(posedge clk) disable iff (rst)
    hdr_irq == (hdr_flag && $past(irq_en)));

  p_flag_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(hdr_flag) |-> $past(ctrl_rd));

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (hdr_flag && !ctrl_rd) |=> hdr_flag);

  p_sync_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_state) |-> $past(bit_tick && !rx));

  p_sync_exit_r4: assert property (@(posedge clk) disable iff (rst)
    (sync_exit && !bit_tick) |=> !sync_state);

  p_edge_bound_r5: assert property (@(posedge clk) disable iff (rst)
    edge_cnt <= EDGE_W'(SYNC_EDGES));
endmodule

bind lin_hdr_detect lin_hdr_chk #(.SYNC_EDGES(SYNC_EDGES), .EDGE_W(EDGE_W)) u_chk (
  .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx(rx), .sync_exit(sync_exit),
  .irq_en(irq_en), .ctrl_rd(ctrl_rd), .hdr_flag(hdr_flag),
  .sync_state(sync_state), .hdr_irq(hdr_irq), .edge_cnt(edge_cnt)
);

// File: tb/test_lin_hdr_detect.sv
module test_lin_hdr_detect;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_tick = 1'b0, rx = 1'b1, hdr_method = 1'b0, irq_en = 1'b0;
  logic sync_exit = 1'b0, stat_rd = 1'b0, ctrl_rd = 1'b0;
  logic hdr_flag, sync_state, hdr_irq;
  logic [2:0] edge_cnt;
  logic [7:0] sync_span, id_byte;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lin_hdr_detect i_lin_hdr_detect (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx(rx), .hdr_method(hdr_method),
    .irq_en(irq_en), .sync_exit(sync_exit), .stat_rd(stat_rd), .ctrl_rd(ctrl_rd),
    .hdr_flag(hdr_flag), .sync_state(sync_state), .hdr_irq(hdr_irq),
    .edge_cnt(edge_cnt), .sync_span(sync_span), .id_byte(id_byte)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); rx = b; bit_tick = 1'b1;
    @(negedge clk); bit_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_low(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  task automatic send_char(input logic [7:0] b, input logic stopv);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    send_bit(stopv);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic clear_flag();
    pulse(stat_rd);
    pulse(ctrl_rd);
  endtask

  task automatic send_frame(input int brk, input logic [7:0] id, input logic stop_ok);
    send_low(brk);
    send_bit(1'b1);
    send_char(8'h55, 1'b1);
    send_bit(1'b1);
    send_char(id, stop_ok);
    send_bit(1'b1);
  endtask

  function automatic int exp_flag(input logic meth, input logic stop_ok);
    return meth ? int'(stop_ok) : 1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] last_id;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("reset flag", hdr_flag, 0);
    chk("reset sync", sync_state, 0);
    chk("reset irq", hdr_irq, 0);
    chk("reset edge", edge_cnt, 0);

    // R1 / R2 / R3 / R9: break threshold, method 0
    irq_en = 1'b1;
    send_low(10);
    chk("R1 ten lows no break", sync_state, 0);
    chk("R2 ten lows no flag", hdr_flag, 0);
    send_bit(1'b0);
    chk("R1 eleventh low", sync_state, 1);
    chk("R2 flag at break", hdr_flag, 1);
    chk("R9 irq with enable", hdr_irq, 1);
    send_low(3);
    chk("R1 long run single break", edge_cnt, 0);
    send_bit(1'b1);
    send_char(8'h55, 1'b1);
    chk("R5 edge count", edge_cnt, 5);
    chk("R5 span", sync_span, 8);
    chk("R3 sync cleared", sync_state, 0);
    send_bit(1'b1);
    send_char(8'hA3, 1'b1);
    chk("R6 ident lsb first", id_byte, 8'hA3);
    send_bit(1'b1);

    // R8: clear sequence ordering
    pulse(ctrl_rd);
    chk("R8 ctrl alone", hdr_flag, 1);
    clear_flag();
    chk("R8 stat then ctrl", hdr_flag, 0);
    chk("R9 irq follows clear", hdr_irq, 0);
    pulse(stat_rd);
    send_low(11);
    send_bit(1'b1);
    pulse(ctrl_rd);
    chk("R8 header between reads", hdr_flag, 1);

    // R10: new break with flag set
    send_char(8'h55, 1'b1);
    chk("R10 pre edge", edge_cnt, 5);
    send_low(11);
    chk("R10 flag kept", hdr_flag, 1);
    chk("R10 sync restart", sync_state, 1);
    chk("R10 edge restart", edge_cnt, 0);

    // R4: software exit
    pulse(sync_exit);
    chk("R4 exit clears", sync_state, 0);
    send_bit(1'b1);
    send_char(8'h55, 1'b1);
    chk("R4 edges ignored", edge_cnt, 0);
    send_bit(1'b1);
    send_char(8'h11, 1'b1);
    chk("R4 no ident", id_byte, 8'hA3);
    clear_flag();

    // R2 method 1 path / R6
    hdr_method = 1'b1;
    send_low(11);
    chk("R2 m1 no flag at break", hdr_flag, 0);
    send_bit(1'b1);
    send_char(8'h55, 1'b1);
    chk("R6 m1 no flag after sync", hdr_flag, 0);
    send_bit(1'b1);
    send_char(8'h3C, 1'b1);
    chk("R6 m1 flag after ident", hdr_flag, 1);
    chk("R6 m1 ident", id_byte, 8'h3C);
    send_bit(1'b1);
    clear_flag();

    // R7: bad stop bit
    irq_en = 1'b0;
    send_frame(11, 8'hFF, 1'b0);
    chk("R7 no flag", hdr_flag, 0);
    chk("R7 ident kept", id_byte, 8'h3C);
    hdr_method = 1'b0;
    send_frame(12, 8'h5A, 1'b1);
    chk("R9 irq masked", hdr_irq, 0);
    chk("R9 flag set masked", hdr_flag, 1);
    last_id = 8'h5A;

    // random frames
    for (int n = 0; n < 40; n++) begin
      logic m, en, ok;
      logic [7:0] id;
      int brk;
      clear_flag();
      m   = 1'($urandom % 2);
      en  = 1'($urandom % 2);
      ok  = ($urandom % 4) != 0;
      id  = 8'($urandom);
      brk = 11 + int'($urandom % 5);
      hdr_method = m; irq_en = en;
      send_frame(brk, id, ok);
      if (ok) last_id = id;
      chk("R2 R6 R7 rand flag", hdr_flag, exp_flag(m, ok));
      chk("R9 rand irq", hdr_irq, exp_flag(m, ok) & int'(en));
      chk("R6 R7 rand ident", id_byte, last_id);
      chk("R5 rand span", sync_span, 8);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule